// File: doc/BRIEF.md
# Local Bus Cycle Timeout Monitor

This block watches every local bus cycle from the clock in which it starts until the clock in which it is acknowledged. A free-running microsecond tick drives a per-cycle counter. The counter restarts at each cycle start and stops when the cycle finishes normally. If the count reaches the limit that software has chosen before the cycle finishes, the block sends a one-clock transfer-error acknowledge back to the bus master, and that ends the cycle.

Software picks one of three finite limits with a 2-bit select, or picks no limit at all. The monitor does nothing unless its enable bit is set. A cycle that is flagged at its start as going out to the external backplane is not timed, because other timers cover that traffic. Each error acknowledge also sets a sticky status bit, which stays set until software clears it with a write strobe.

Top module: `lbus_timeout_mon`

## Requirements
- R1: When `mon_en` is low, no tick advances the cycle count and `terr_ack` stays low.
- R2: The counter clears in the start clock, and only ticks in the clocks that follow it are counted. The tick that brings the count to the limit raises `terr_ack` in the next clock. With a tick every P clocks, the pulse follows edge limit*P after the start edge.
- R3: `lim_sel` sets the limit: 2'b00 gives 8 ticks, 2'b01 gives 64 ticks and 2'b10 gives 256 ticks. 2'b11 is unlimited and never produces `terr_ack`.
- R4: `cyc_remote` is sampled together with `cyc_start`. A cycle that starts with it high is never timed and never produces `terr_ack`.
- R5: A new `cyc_start` in the middle of a cycle restarts the count from zero. A tick in the same clock as the start is not counted.
- R6: `terr_ack` is high for exactly one clock, and at most once per bus cycle.
- R7: A `cyc_done` in the same clock as the expiring tick suppresses the error. Once a cycle is done, no error is raised for it.
- R8: `terr_sticky` rises together with `terr_ack` and stays high until a `stat_clr` clock. If a set and a clear fall in the same clock, the set wins.
- R9: While reset is held, and right after it, `terr_ack` and `terr_sticky` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe marking the start of a bus cycle |
| cyc_done | input | 1 | Normal acknowledge of the current cycle |
| cyc_remote | input | 1 | Cycle is bound for the backplane (sampled with the start) |
| mon_en | input | 1 | Monitor enable |
| lim_sel | input | 2 | Limit select (8/64/256 ticks, or unlimited) |
| us_tick | input | 1 | One-clock microsecond tick |
| stat_clr | input | 1 | Software write strobe that clears the sticky status |
| terr_ack | output | 1 | One-clock transfer-error acknowledge |
| terr_sticky | output | 1 | Sticky timeout status |

## Verification
Exactly one register stands between the expiring tick and `terr_ack`, so the pulse is due in the clock right after edge limit*P, counting the start edge as edge 0. The sticky bit changes at that same edge. A clear takes effect one edge after its strobe. The bench drives every input on the falling edge. It samples the outputs on the next falling edge, which comes after exactly one rising edge, so every sample sits at a known edge number. It compares the first edge at which a pulse appears, and the number of pulses, with limit*P computed in the bench. It runs this over all selects, enable and remote settings, two tick periods, and done placed at, after, or never relative to the expiry edge.

// File: rtl/lbto_pkg.sv
package lbto_pkg;
  typedef enum logic [1:0] {
    SEL_SHORT = 2'b00,
    SEL_MID   = 2'b01,
    SEL_LONG  = 2'b10,
    SEL_NONE  = 2'b11
  } lim_sel_e;
endpackage

// File: rtl/lbto_limit_dec.sv
module lbto_limit_dec #(
  parameter int LIM_SHORT = 8,
  parameter int LIM_MID   = 64,
  parameter int LIM_LONG  = 256,
  parameter int CNT_W     = 9
) (
  input  logic [1:0]       sel,
  output logic [CNT_W-1:0] limit,
  output logic             unlimited
);
  import lbto_pkg::*;

  always_comb begin
    limit     = CNT_W'(LIM_LONG);
    unlimited = 1'b0;
    case (lim_sel_e'(sel))
      SEL_SHORT: limit = CNT_W'(LIM_SHORT);
      SEL_MID:   limit = CNT_W'(LIM_MID);
      SEL_LONG:  limit = CNT_W'(LIM_LONG);
      default:   unlimited = 1'b1;
    endcase
  end
endmodule

// File: rtl/lbto_cycle_ctl.sv
module lbto_cycle_ctl #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             cyc_done,
  input  logic             cyc_remote,
  input  logic             mon_en,
  input  logic             us_tick,
  input  logic [CNT_W-1:0] limit,
  input  logic             unlimited,
  output logic             expire
);
  logic             active_q, active_d;
  logic             exempt_q, exempt_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en, ctl_en;
  logic             counting, reach;

  // timing is live only for a local, enabled, finitely limited cycle
  always_comb begin
    counting = active_q && !exempt_q && mon_en && !unlimited;
    reach    = counting && us_tick && (cnt_q >= (limit - 1'b1));
    // a start or a normal completion in the same clock takes precedence
    expire   = reach && !cyc_done && !cyc_start;
  end

  always_comb begin
    active_d = active_q;
    exempt_d = exempt_q;
    cnt_d    = cnt_q;
    ctl_en   = 1'b0;
    cnt_en   = 1'b0;
    if (cyc_start) begin
      active_d = 1'b1;
      exempt_d = cyc_remote;
      cnt_d    = '0;
      ctl_en   = 1'b1;
      cnt_en   = 1'b1;
    end else if (cyc_done || expire) begin
      active_d = 1'b0;
      ctl_en   = 1'b1;
    end else if (counting && us_tick) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      exempt_q <= 1'b0;
    end else if (ctl_en) begin
      active_q <= active_d;
      exempt_q <= exempt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lbto_status.sv
module lbto_status (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic stat_clr,
  output logic terr_ack,
  output logic terr_sticky
);
  logic ack_q, ack_d;
  logic sticky_q, sticky_d;

  always_comb begin
    ack_d    = expire;
    sticky_d = expire | (sticky_q & ~stat_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      ack_q    <= ack_d;
      sticky_q <= sticky_d;
    end
  end

  assign terr_ack    = ack_q;
  assign terr_sticky = sticky_q;
endmodule

// File: rtl/lbus_timeout_mon.sv
module lbus_timeout_mon #(
  parameter int LIM_SHORT = 8,
  parameter int LIM_MID   = 64,
  parameter int LIM_LONG  = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_start,
  input  logic       cyc_done,
  input  logic       cyc_remote,
  input  logic       mon_en,
  input  logic [1:0] lim_sel,
  input  logic       us_tick,
  input  logic       stat_clr,
  output logic       terr_ack,
  output logic       terr_sticky
);
  localparam int LIM_MAX = (LIM_LONG > LIM_MID) ?
                           ((LIM_LONG > LIM_SHORT) ? LIM_LONG : LIM_SHORT) :
                           ((LIM_MID > LIM_SHORT) ? LIM_MID : LIM_SHORT);
  localparam int CNT_W   = $clog2(LIM_MAX + 1);

  logic [CNT_W-1:0] limit;
  logic             unlimited;
  logic             expire;

  lbto_limit_dec #(
    .LIM_SHORT(LIM_SHORT), .LIM_MID(LIM_MID), .LIM_LONG(LIM_LONG), .CNT_W(CNT_W)
  ) u_dec (
    .sel(lim_sel), .limit(limit), .unlimited(unlimited)
  );

  lbto_cycle_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_done(cyc_done),
    .cyc_remote(cyc_remote), .mon_en(mon_en), .us_tick(us_tick),
    .limit(limit), .unlimited(unlimited), .expire(expire)
  );

  lbto_status u_stat (
    .clk(clk), .rst_n(rst_n), .expire(expire), .stat_clr(stat_clr),
    .terr_ack(terr_ack), .terr_sticky(terr_sticky)
  );
endmodule

// File: rtl/lbus_timeout_mon_chk.sv
module lbus_timeout_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_start,
  input logic       cyc_done,
  input logic       mon_en,
  input logic [1:0] lim_sel,
  input logic       us_tick,
  input logic       stat_clr,
  input logic       terr_ack,
  input logic       terr_sticky
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    terr_ack |=> !terr_ack);
  a_r1_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    terr_ack |-> $past(mon_en));
  a_r3_unlimited_silent: assert property (@(posedge clk) disable iff (!rst_n)
    terr_ack |-> ($past(lim_sel) != 2'b11));
  a_r2_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    terr_ack |-> $past(us_tick));
  a_r7_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    terr_ack |-> (!$past(cyc_done) && !$past(cyc_start)));
  a_r8_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    terr_ack |-> terr_sticky);
  a_r8_sticky_clr: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat_clr) && !terr_ack) |-> !terr_sticky);
  a_r8_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(terr_sticky) && !$past(stat_clr)) |-> terr_sticky);
endmodule

bind lbus_timeout_mon lbus_timeout_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_done(cyc_done),
  .mon_en(mon_en), .lim_sel(lim_sel), .us_tick(us_tick), .stat_clr(stat_clr),
  .terr_ack(terr_ack), .terr_sticky(terr_sticky)
);

// File: tb/lbus_timeout_mon_bench.sv
`timescale 1ns/1ps
module lbus_timeout_mon_bench;
  logic       clk;
  logic       rst_n;
  logic       cyc_start, cyc_done, cyc_remote, mon_en, us_tick, stat_clr;
  logic [1:0] lim_sel;
  logic       terr_ack, terr_sticky;

  int n_vec;
  int n_bad;
  bit done_flag;

  lbus_timeout_mon u_lbus_timeout_mon (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_done(cyc_done),
    .cyc_remote(cyc_remote), .mon_en(mon_en), .lim_sel(lim_sel),
    .us_tick(us_tick), .stat_clr(stat_clr),
    .terr_ack(terr_ack), .terr_sticky(terr_sticky)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int sel);
    case (sel)
      0: return 8;
      1: return 64;
      2: return 256;
      default: return 300;
    endcase
  endfunction

  // start at edge 0; tick on edges k with k%per==0; done on edge dk (0 = never)
  task automatic run_case(input int sel, input bit en, input bit rem,
                          input int per, input int dsel);
    int fe, dk, w, first, pulses;
    bit exp_fire;
    fe = lim_of(sel) * per;
    dk = (dsel == 0) ? 0 : ((dsel == 1) ? fe : fe + 1);
    exp_fire = en && !rem && (sel != 3) && (dsel != 1);
    w = fe + 8;
    // clear sticky first (R8)
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    check(terr_sticky == 1'b0, "R8 clear", terr_sticky, 0);
    lim_sel = 2'(sel); mon_en = en; cyc_remote = rem; cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0; cyc_remote = 1'b0;
    first = -1; pulses = 0;
    for (int k = 1; k <= w; k++) begin
      us_tick  = (k % per == 0);
      cyc_done = (k == dk);
      @(negedge clk);
      if (terr_ack) begin
        pulses++;
        if (first < 0) first = k;
      end
    end
    us_tick = 1'b0; cyc_done = 1'b0;
    if (exp_fire) begin
      check(first == fe, "R2/R3 expiry edge", first, fe);
      check(pulses == 1, "R6 pulse count", pulses, 1);
    end else begin
      if (!en)              check(pulses == 0, "R1 disabled", pulses, 0);
      else if (rem)         check(pulses == 0, "R4 remote", pulses, 0);
      else if (sel == 3)    check(pulses == 0, "R3 unlimited", pulses, 0);
      else                  check(pulses == 0, "R7 done wins", pulses, 0);
    end
    check(terr_sticky == exp_fire, "R8 sticky", terr_sticky, int'(exp_fire));
  endtask

  initial begin
    n_vec = 0; n_bad = 0; done_flag = 1'b0;
    rst_n = 1'b0;
    cyc_start = 0; cyc_done = 0; cyc_remote = 0; mon_en = 0;
    us_tick = 0; stat_clr = 0; lim_sel = 2'b00;
    repeat (3) @(negedge clk);
    check(terr_ack == 1'b0 && terr_sticky == 1'b0, "R9 in reset",
          {terr_ack, terr_sticky}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(terr_ack == 1'b0 && terr_sticky == 1'b0, "R9 after reset",
          {terr_ack, terr_sticky}, 0);

    for (int sel = 0; sel < 4; sel++)
      for (int en = 0; en < 2; en++)
        for (int rem = 0; rem < 2; rem++)
          for (int pi = 0; pi < 2; pi++)
            for (int d = 0; d < 3; d++)
              run_case(sel, en[0], rem[0], (pi == 0) ? 1 : 3, d);

    // R5: restart mid-cycle; tick in the start clock is not counted
    begin
      int first;
      lim_sel = 2'b00; mon_en = 1'b1; cyc_remote = 1'b0;
      @(negedge clk); cyc_start = 1'b1;
      @(negedge clk); cyc_start = 1'b0; us_tick = 1'b1;
      repeat (5) @(negedge clk);
      cyc_start = 1'b1;
      @(negedge clk); cyc_start = 1'b0;
      first = -1;
      for (int k = 1; k <= 16; k++) begin
        @(negedge clk);
        if (terr_ack && first < 0) first = k;
      end
      us_tick = 1'b0;
      check(first == 8, "R5 restart", first, 8);
    end

    // R8: set and clear in the same clock, set wins
    begin
      lim_sel = 2'b00; mon_en = 1'b1;
      @(negedge clk); cyc_start = 1'b1;
      @(negedge clk); cyc_start = 1'b0;
      repeat (7) begin us_tick = 1'b1; @(negedge clk); us_tick = 1'b0; end
      us_tick = 1'b1; stat_clr = 1'b1;
      @(negedge clk);
      us_tick = 1'b0; stat_clr = 1'b0;
      check(terr_ack == 1'b1, "R2 pulse at 8th tick", terr_ack, 1);
      check(terr_sticky == 1'b1, "R8 set beats clear", terr_sticky, 1);
      @(negedge clk);
      check(terr_ack == 1'b0, "R6 one clock", terr_ack, 0);
    end

    done_flag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule